// File: doc/BRIEF.md
# Tree Sum Reduction Engine

The engine takes a set of partial sums, one per virtual processor lane, and combines them into a single total. It does this through a series of synchronized halving rounds. A single clock edge captures all N partial sums from a flat input bus when a start pulse arrives while the engine is idle. The engine then performs one round per clock cycle. In each round the active count shrinks by half, and every lane below the new count adds its partner slot, found at its own index plus the new count, into its own slot. When the count is odd, lane 0 also absorbs the unpaired top element in the same round. Because of this, any N is reduced correctly, not only powers of two.

Each round ends on a register boundary, so the clock edge acts as the barrier between reduction steps. When the count reaches one, the total sits in slot 0 and a one-cycle done pulse marks it. The result stays on the output until the next accepted start. Lane count and data width are parameters. All additions wrap modulo 2^W.

Top module: `tree_sum_reduce`

## Requirements
- R1: A start_i pulse sampled while the engine is idle captures all N lane values from sums_i (lane k at bits k*W to k*W+W-1) on that same edge and begins reduction.
- R2: Each round halves the active count with integer division, and lane i below the new count adds the slot at index i plus the new count into slot i. The final result equals the sum of all N captured values.
- R3: done_o is high for exactly one cycle. It is sampled high floor(log2 N) clock edges after the edge that captured the inputs: 3 edges for N=10 (count 10, 5, 2, 1) and 2 edges for N=7 (7, 3, 1).
- R4: When the active count at the start of a round is odd, slot 0 also adds the element at index count minus 1 in that round, so no element is lost for any N.
- R5: Additions wrap modulo 2^W, and no overflow indication exists.
- R6: start_i asserted while a reduction is in progress is ignored. The running reduction keeps its inputs, its result and its done timing.
- R7: After done_o, result_o holds the total unchanged until the next accepted start, whatever sums_i does.
- R8: While rst_ni is low, done_o is 0 and result_o is 0, including when reset interrupts a reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reduction; sampled only when idle |
| sums_i | input | N_LANES*DATA_W | Initial partial sums, lane k in slice k |
| done_o | output | 1 | One-cycle pulse when the total is ready |
| result_o | output | DATA_W | Contents of slot 0; the total after done_o |

## Verification
A wrong partner index, a missed odd fold or a lost carry shows up as a wrong result_o in the cycle done_o rises. That is floor(log2 N) edges after capture, so at most a handful of cycles. A wrong half counter moves the done pulse earlier or later, and the bench compares the edge count exactly. Vectors that put their only non-zero value in the leftover position of an odd round make a skipped fold visible as a zero total. A start leaking through during a run shows up as a changed total or a shifted done pulse.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tsr_state_e;

  // number of halving rounds until the count reaches one
  function automatic int tsr_rounds(input int n);
    int cnt;
    int h;
    cnt = 0;
    h   = n;
    while (h > 1) begin
      h   = h / 2;
      cnt = cnt + 1;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/tsr_half_ctrl.sv
module tsr_half_ctrl
  import tsr_pkg::*;
#(
  parameter int N_LANES = 10,
  parameter int HALF_W  = $clog2(N_LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              load_o,
  output logic              round_o,
  output logic [HALF_W-1:0] half_o,
  output logic              busy_o,
  output logic              done_o
);

  tsr_state_e        state_q;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] half_nxt;
  logic              done_q;

  assign load_o   = start_i && (state_q == ST_IDLE);
  assign round_o  = (state_q == ST_RUN);
  assign half_nxt = half_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= HALF_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        half_q  <= HALF_W'(N_LANES);
        state_q <= (N_LANES > 1) ? ST_RUN : ST_IDLE;
        done_q  <= (N_LANES == 1);
      end else if (round_o) begin
        half_q <= half_nxt;
        if (half_nxt == HALF_W'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign half_o = half_q;
  assign busy_o = round_o;
  assign done_o = done_q;

endmodule

// File: rtl/tsr_lane_array.sv
module tsr_lane_array #(
  parameter int N_LANES = 10,
  parameter int DATA_W  = 16,
  parameter int HALF_W  = $clog2(N_LANES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      round_i,
  input  logic [HALF_W-1:0]         half_i,
  input  logic [N_LANES*DATA_W-1:0] sums_i,
  output logic [DATA_W-1:0]         slot0_o
);

  logic [DATA_W-1:0] slot_w [N_LANES];
  logic [HALF_W-1:0] half_nxt;
  logic              odd_fold;

  assign half_nxt = half_i >> 1;
  assign odd_fold = half_i[0];

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic [DATA_W-1:0] partner;
    logic [DATA_W-1:0] extra;
    logic              active;

    assign active = (i < int'(half_nxt));

    always_comb begin
      partner = '0;
      for (int j = 0; j < N_LANES; j++) begin
        if (j == i + int'(half_nxt)) partner = slot_w[j];
      end
    end

    if (i == 0) begin : g_fold
      // lane 0 absorbs the unpaired top element on odd counts
      always_comb begin
        extra = '0;
        for (int j = 0; j < N_LANES; j++) begin
          if (odd_fold && (j + 1 == int'(half_i))) extra = slot_w[j];
        end
      end
    end else begin : g_nofold
      assign extra = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (load_i) begin
        lane_q <= sums_i[i*DATA_W +: DATA_W];
      end else if (round_i && active) begin
        lane_q <= lane_q + partner + extra;
      end
    end

    assign slot_w[i] = lane_q;
  end

  assign slot0_o = slot_w[0];

endmodule

// File: rtl/tree_sum_reduce.sv
module tree_sum_reduce #(
  parameter int N_LANES = 10,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [N_LANES*DATA_W-1:0] sums_i,
  output logic                      done_o,
  output logic [DATA_W-1:0]         result_o
);

  localparam int HALF_W = $clog2(N_LANES + 1);

  logic              load_en;
  logic              round_en;
  logic              busy;
  logic [HALF_W-1:0] half_q;

  tsr_half_ctrl #(
    .N_LANES(N_LANES),
    .HALF_W (HALF_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load_en),
    .round_o(round_en),
    .half_o (half_q),
    .busy_o (busy),
    .done_o (done_o)
  );

  tsr_lane_array #(
    .N_LANES(N_LANES),
    .DATA_W (DATA_W),
    .HALF_W (HALF_W)
  ) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .round_i(round_en),
    .half_i (half_q),
    .sums_i (sums_i),
    .slot0_o(result_o)
  );

endmodule

// File: rtl/tree_sum_reduce_chk.sv
module tree_sum_reduce_chk
  import tsr_pkg::*;
#(
  parameter int N_LANES = 10,
  parameter int DATA_W  = 16,
  parameter int HALF_W  = $clog2(N_LANES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              load_en,
  input logic              busy,
  input logic [HALF_W-1:0] half_q
);

  localparam int ROUNDS = tsr_rounds(N_LANES);

  logic [7:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= '0;
    else if (load_en) run_cnt <= '0;
    else if (busy)    run_cnt <= run_cnt + 8'd1;
  end

  a_r1_load_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en && (N_LANES > 1)) |=> busy);

  a_r2_half_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (half_q < $past(half_q)));

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == 8'(ROUNDS)));

  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |-> !load_en);

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load_en) |=> $stable(result_o));

endmodule

bind tree_sum_reduce tree_sum_reduce_chk #(
  .N_LANES(N_LANES),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .result_o(result_o),
  .load_en (load_en),
  .busy    (busy),
  .half_q  (half_q)
);

// File: tb/tree_sum_reduce_bench.sv
module tree_sum_reduce_bench;

  localparam int W   = 16;
  localparam int NA  = 10;
  localparam int NB  = 7;

  typedef struct packed {
    logic [NA*W-1:0] sums;
    logic [W-1:0]    exp;
  } vec_t;

  // lane 9 first ... lane 0 last
  localparam vec_t VECS [4] = '{
    '{ {16'd10,16'd9,16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1}, 16'd55 },
    '{ {10{16'hFFFF}}, 16'hFFF6 },
    '{ {16'd0,16'd0,16'd0,16'd0,16'd0,16'd100,16'd0,16'd0,16'd0,16'd0}, 16'd100 },
    '{ {16'd7,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd3}, 16'd10 }
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_a = 1'b0;
  logic            start_b = 1'b0;
  logic [NA*W-1:0] sums_a = '0;
  logic [NB*W-1:0] sums_b = '0;
  logic            done_a, done_b;
  logic [W-1:0]    res_a, res_b;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tree_sum_reduce #(.N_LANES(NA), .DATA_W(W)) u_tree_sum_reduce (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .sums_i(sums_a),
    .done_o(done_a), .result_o(res_a)
  );

  tree_sum_reduce #(.N_LANES(NB), .DATA_W(W)) u_tree_sum_reduce_n7 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .sums_i(sums_b),
    .done_o(done_b), .result_o(res_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run on instance A; returns edges until done and result
  task automatic run_a(input logic [NA*W-1:0] s, input bit poke_start,
                       output int lat, output logic [W-1:0] res);
    lat = -1;
    @(negedge clk);
    sums_a  = s;
    start_a = 1'b1;
    @(negedge clk);
    start_a = poke_start;
    if (poke_start) sums_a = {NA{16'h1111}};
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      start_a = 1'b0;
      if (done_a && lat < 0) begin
        lat = k;
        res = res_a;
        break;
      end
    end
    if (lat < 0) res = res_a;
  endtask

  initial begin
    int lat;
    logic [W-1:0] res;

    // R8 reset state
    #3;
    chk(done_a == 1'b0, "R8 done in reset", done_a, 0);
    chk(res_a == '0, "R8 result in reset", res_a, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: table walk
    for (int v = 0; v < 4; v++) begin
      run_a(VECS[v].sums, 1'b0, lat, res);
      chk(res == VECS[v].exp, $sformatf("R2 R4 R5 vec%0d result", v), res, VECS[v].exp);
      chk(lat == 3, $sformatf("R1 R3 vec%0d latency", v), lat, 3);
      @(negedge clk);
      chk(done_a == 1'b0, $sformatf("R3 vec%0d done one cycle", v), done_a, 0);
    end

    // R7 hold after done while sums_i changes
    sums_a = {NA{16'h0F0F}};
    repeat (3) @(negedge clk);
    chk(res_a == 16'd10, "R7 result held", res_a, 10);
    chk(done_a == 1'b0, "R7 no spurious done", done_a, 0);

    // R6 start while busy ignored
    run_a({16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd42}, 1'b1, lat, res);
    chk(res == 16'd42, "R6 busy start ignored result", res, 42);
    chk(lat == 3, "R6 busy start ignored latency", lat, 3);

    // R4 odd chain on N=7: 7 -> 3 -> 1, values 1..64
    @(negedge clk);
    sums_b  = {16'd64,16'd32,16'd16,16'd8,16'd4,16'd2,16'd1};
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    @(negedge clk);
    chk(done_b == 1'b0, "R3 n7 not done after 1", done_b, 0);
    @(negedge clk);
    chk(done_b == 1'b1, "R3 n7 done after 2", done_b, 1);
    chk(res_b == 16'd127, "R4 n7 total", res_b, 127);

    // R4 leftover-only element in N=7 (index 6, then index 2 path)
    @(negedge clk);
    sums_b  = {16'd9,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0};
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    repeat (2) @(negedge clk);
    chk(done_b && res_b == 16'd9, "R4 n7 leftover folded", res_b, 9);

    // R8 reset in mid-run
    @(negedge clk);
    sums_a  = {NA{16'd5}};
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(res_a == '0, "R8 mid-run reset result", res_a, 0);
    chk(done_a == 1'b0, "R8 mid-run reset done", done_a, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_a == 1'b0 && res_a == '0, "R8 idle after reset", res_a, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule